// File: doc/BRIEF.md
# Time-of-Day Snapshot Register Front End

This block sits between a 32-bit memory-mapped register bus and a free-running time-of-day counter. The counter keeps a 48-bit seconds value and a 32-bit nanoseconds value. Software cannot read that full time in one bus access. The block therefore freezes a coherent copy of the seconds at the moment the nanoseconds word is read. The later reads of the two seconds words return that frozen copy and not the live count.

In the other direction, software first places the new seconds in two shadow words. Writing the nanoseconds word then loads the counter in a single step. It does so with a one-cycle load pulse that carries the complete new time. A read-only word reports the counter clock frequency, which is fixed at build time.

The bus is a plain strobe interface: `req_i` with `we_i` starts a one-cycle access. Read data is registered and appears on `rdata_o` after the clock edge that samples the strobe. `rdata_o` holds that value until the next read.

Top module: `tod_snap_regs`

## Requirements
- R1: After reset, `rdata_o` is 0 and `load_o` is 0. The seconds snapshot is zero, so reads of the seconds-low and seconds-high words that come before any nanoseconds read return 0.
- R2: A read of the nanoseconds word (offset 0x108) returns `live_ns_i` as sampled at the strobe edge. The value is on `rdata_o` from that edge onward.
- R3: A read of offset 0x108 copies `live_sec_i` into the snapshot at the same edge. Later reads of seconds-low and seconds-high return that copy until the next read of 0x108, whatever `live_sec_i` does in between.
- R4: The seconds-high word (offset 0x100) reads as snapshot seconds[47:32] in bits [15:0], and bits [31:16] read as zero. The seconds-low word (offset 0x104) reads as snapshot seconds[31:0].
- R5: Writes to 0x100 or 0x104 only update shadow registers. `load_o` stays 0 in the cycle after such a write.
- R6: A write to 0x108 raises `load_o` for exactly one cycle after the strobe edge. During that cycle `load_sec_o` = {shadow_hi[15:0], shadow_lo} and `load_ns_o` is the written data.
- R7: Writes to bits [31:16] of the seconds-high word are ignored. They never appear in `load_sec_o`.
- R8: Offset 0x038 reads as the parameter `CLK_FREQ`. A write to it has no effect on later reads of it and produces no load.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets produce no load.
- R10: Reads of the seconds words do not change the snapshot. Two reads of seconds-low in a row, with the live time changing between them, return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| live_sec_i | input | 48 | Live seconds from the counter |
| live_ns_i | input | 32 | Live nanoseconds from the counter |
| load_o | output | 1 | One-cycle load strobe to the counter |
| load_sec_o | output | 48 | Seconds to load |
| load_ns_o | output | 32 | Nanoseconds to load |

## Verification
Every stored state in this block reaches the ports within one access. A bad snapshot register appears on the next seconds-word read as a value that tracks the live seconds or is stale. A bad shadow register shows up in `load_sec_o` on the first nanoseconds write that follows. The live inputs are changed between the reads, so a design that returns live seconds instead of captured ones gives a different value at once. The bench also samples the cycle after each load, which shows a load strobe stuck high or one that was lost.

// File: rtl/tod_regs_pkg.sv
package tod_regs_pkg;
  localparam logic [31:0] OFS_FREQ   = 32'h038;
  localparam logic [31:0] OFS_SEC_HI = 32'h100;
  localparam logic [31:0] OFS_SEC_LO = 32'h104;
  localparam logic [31:0] OFS_NSEC   = 32'h108;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FREQ,
    SEL_SEC_HI,
    SEL_SEC_LO,
    SEL_NSEC
  } reg_sel_e;
endpackage

// File: rtl/tod_addr_dec.sv
module tod_addr_dec
  import tod_regs_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);
  // word-aligned decode; byte lanes ignored
  localparam int unsigned WA_W = AW - 2;

  logic [WA_W-1:0] wa;
  assign wa = addr_i[AW-1:2];

  always_comb begin
    sel_o = SEL_NONE;
    if (wa == OFS_FREQ[AW-1:2])        sel_o = SEL_FREQ;
    else if (wa == OFS_SEC_HI[AW-1:2]) sel_o = SEL_SEC_HI;
    else if (wa == OFS_SEC_LO[AW-1:2]) sel_o = SEL_SEC_LO;
    else if (wa == OFS_NSEC[AW-1:2])   sel_o = SEL_NSEC;
  end
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot #(
  parameter int unsigned SEC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [SEC_W-1:0] live_sec_i,
  output logic [SEC_W-1:0] snap_sec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_sec_o <= '0;
    else if (capture_i) snap_sec_o <= live_sec_i;
  end
endmodule

// File: rtl/tod_stage.sv
module tod_stage #(
  parameter int unsigned DW    = 32,
  parameter int unsigned SEC_W = 48,
  parameter int unsigned NS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic             wr_ns_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             load_o,
  output logic [SEC_W-1:0] load_sec_o,
  output logic [NS_W-1:0]  load_ns_o
);
  localparam int unsigned HI_W = SEC_W - DW;

  logic [HI_W-1:0] shadow_hi;
  logic [DW-1:0]   shadow_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_hi <= '0;
      shadow_lo <= '0;
    end else begin
      if (wr_hi_i) shadow_hi <= wdata_i[HI_W-1:0];
      if (wr_lo_i) shadow_lo <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o     <= 1'b0;
      load_sec_o <= '0;
      load_ns_o  <= '0;
    end else begin
      load_o <= wr_ns_i;
      if (wr_ns_i) begin
        load_sec_o <= {shadow_hi, shadow_lo};
        load_ns_o  <= wdata_i[NS_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tod_snap_regs.sv
module tod_snap_regs
  import tod_regs_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 32,
  parameter int unsigned SEC_W    = 48,
  parameter int unsigned NS_W     = 32,
  parameter logic [31:0] CLK_FREQ = 32'd100_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [SEC_W-1:0] live_sec_i,
  input  logic [NS_W-1:0]  live_ns_i,
  output logic             load_o,
  output logic [SEC_W-1:0] load_sec_o,
  output logic [NS_W-1:0]  load_ns_o
);
  localparam int unsigned HI_W  = SEC_W - DW;
  localparam int unsigned PAD_W = 2 * DW - SEC_W;

  reg_sel_e         sel;
  logic             rd, wr;
  logic [SEC_W-1:0] snap_sec;
  logic [DW-1:0]    rd_mux;

  assign rd = req_i && !we_i;
  assign wr = req_i &&  we_i;

  tod_addr_dec #(.AW(AW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  tod_snapshot #(.SEC_W(SEC_W)) u_snap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (rd && sel == SEL_NSEC),
    .live_sec_i (live_sec_i),
    .snap_sec_o (snap_sec)
  );

  tod_stage #(.DW(DW), .SEC_W(SEC_W), .NS_W(NS_W)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hi_i    (wr && sel == SEL_SEC_HI),
    .wr_lo_i    (wr && sel == SEL_SEC_LO),
    .wr_ns_i    (wr && sel == SEL_NSEC),
    .wdata_i    (wdata_i),
    .load_o     (load_o),
    .load_sec_o (load_sec_o),
    .load_ns_o  (load_ns_o)
  );

  // nanoseconds come straight from the live counter, captured with the seconds
  logic [DW-1:0] ns_ext;
  generate
    if (NS_W >= DW) begin : g_ns_full
      assign ns_ext = live_ns_i[DW-1:0];
    end else begin : g_ns_pad
      assign ns_ext = {{(DW - NS_W){1'b0}}, live_ns_i};
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_FREQ:   rd_mux = CLK_FREQ[DW-1:0];
      SEL_SEC_HI: rd_mux = {{PAD_W{1'b0}}, snap_sec[SEC_W-1:DW]};
      SEL_SEC_LO: rd_mux = snap_sec[DW-1:0];
      SEL_NSEC:   rd_mux = ns_ext;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/tod_snap_regs_chk.sv
module tod_snap_regs_chk
  import tod_regs_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 32,
  parameter int unsigned SEC_W    = 48,
  parameter logic [31:0] CLK_FREQ = 32'd100_000_000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    rdata_o,
  input logic [SEC_W-1:0] live_sec_i,
  input logic             load_o,
  input logic [SEC_W-1:0] snap_sec
);
  logic a_ns, a_hi, a_lo, a_fr, a_map;
  assign a_ns  = addr_i[AW-1:2] == OFS_NSEC[AW-1:2];
  assign a_hi  = addr_i[AW-1:2] == OFS_SEC_HI[AW-1:2];
  assign a_lo  = addr_i[AW-1:2] == OFS_SEC_LO[AW-1:2];
  assign a_fr  = addr_i[AW-1:2] == OFS_FREQ[AW-1:2];
  assign a_map = a_ns || a_hi || a_lo || a_fr;

  p_snap_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && a_ns) |=> snap_sec == $past(live_sec_i));

  p_snap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i && a_ns) |=> $stable(snap_sec));

  p_hi_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && a_hi) |=> rdata_o[DW-1:SEC_W-DW] == '0);

  p_load_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(req_i && we_i && a_ns));

  p_no_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !a_ns) |=> !load_o);

  p_freq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && a_fr) |=> rdata_o == CLK_FREQ[DW-1:0]);

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !a_map) |=> rdata_o == '0);
endmodule

bind tod_snap_regs tod_snap_regs_chk #(
  .AW(AW), .DW(DW), .SEC_W(SEC_W), .CLK_FREQ(CLK_FREQ)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .live_sec_i (live_sec_i),
  .load_o     (load_o),
  .snap_sec   (snap_sec)
);

// File: tb/tod_snap_regs_tb.sv
module tod_snap_regs_tb;
  localparam logic [31:0] FREQ = 32'd100_000_000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [47:0] live_sec_i = '0;
  logic [31:0] live_ns_i = '0;
  logic        load_o;
  logic [47:0] load_sec_o;
  logic [31:0] load_ns_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tod_snap_regs #(.CLK_FREQ(FREQ)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .live_sec_i(live_sec_i), .live_ns_i(live_ns_i),
    .load_o(load_o), .load_sec_o(load_sec_o), .load_ns_o(load_ns_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one access at a negedge, sample one negedge later (after the strobe edge)
  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata reset", 64'(rdata_o), 64'h0);
    chk("R1 load reset", 64'(load_o), 64'h0);
    live_sec_i = 48'hABCD_1111_2222;
    bus(1'b0, 12'h104, '0);
    chk("R1 sec_lo before snapshot", 64'(rdata_o), 64'h0);
    bus(1'b0, 12'h100, '0);
    chk("R1 sec_hi before snapshot", 64'(rdata_o), 64'h0);
  endtask

  task automatic t_snapshot();
    live_sec_i = 48'h1234_89AB_CDEF;
    live_ns_i  = 32'd999_999_000;
    bus(1'b0, 12'h108, '0);
    chk("R2 nsec live", 64'(rdata_o), 64'd999_999_000);
    live_sec_i = 48'h0000_0000_0005;
    live_ns_i  = 32'd7;
    bus(1'b0, 12'h104, '0);
    chk("R3 sec_lo frozen", 64'(rdata_o), 64'h89AB_CDEF);
    live_sec_i = 48'hFFFF_FFFF_FFFF;
    bus(1'b0, 12'h100, '0);
    chk("R4 sec_hi layout", 64'(rdata_o), 64'h0000_1234);
    bus(1'b0, 12'h104, '0);
    chk("R10 sec_lo reread", 64'(rdata_o), 64'h89AB_CDEF);
    bus(1'b0, 12'h108, '0);
    chk("R2 nsec second read", 64'(rdata_o), 64'd7);
    bus(1'b0, 12'h100, '0);
    chk("R4 sec_hi upper zero", 64'(rdata_o), 64'h0000_FFFF);
    bus(1'b0, 12'h104, '0);
    chk("R3 new snapshot lo", 64'(rdata_o), 64'hFFFF_FFFF);
  endtask

  task automatic t_write();
    bus(1'b1, 12'h100, 32'hFFFF_5A5A);
    chk("R5 no load after hi", 64'(load_o), 64'h0);
    bus(1'b1, 12'h104, 32'h0102_0304);
    chk("R5 no load after lo", 64'(load_o), 64'h0);
    bus(1'b1, 12'h108, 32'd500);
    chk("R6 load pulse", 64'(load_o), 64'h1);
    chk("R7 load seconds", 64'(load_sec_o), 64'h5A5A_0102_0304);
    chk("R6 load nsec", 64'(load_ns_o), 64'd500);
    @(negedge clk_i);
    chk("R6 pulse one cycle", 64'(load_o), 64'h0);
    bus(1'b1, 12'h100, 32'h8000_0001);
    bus(1'b1, 12'h108, 32'd1);
    chk("R7 upper bits dropped", 64'(load_sec_o), 64'h0001_0102_0304);
  endtask

  task automatic t_freq_unmapped();
    bus(1'b0, 12'h038, '0);
    chk("R8 freq read", 64'(rdata_o), 64'(FREQ));
    bus(1'b1, 12'h038, 32'h1);
    chk("R8 freq write no load", 64'(load_o), 64'h0);
    bus(1'b0, 12'h038, '0);
    chk("R8 freq after write", 64'(rdata_o), 64'(FREQ));
    bus(1'b0, 12'h10C, '0);
    chk("R9 unmapped 0x10C", 64'(rdata_o), 64'h0);
    bus(1'b0, 12'h000, '0);
    chk("R9 unmapped 0x000", 64'(rdata_o), 64'h0);
    bus(1'b1, 12'h200, 32'h5);
    chk("R9 unmapped write no load", 64'(load_o), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_snapshot();
    t_write();
    t_freq_unmapped();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule